// File: doc/BRIEF.md
# Line-Timed Clamp and AGC Gate Generator

This block produces two active-high pulses on every video line. One is a gate for sampling the automatic gain control at the sync tip. The other is a gate for clamping the black level on the back porch. A pixel-rate counter times both pulses. The counter restarts on a one-cycle strobe that marks the falling edge of horizontal sync. Four start/end registers, supplied from outside, place the pulses within the line. A window whose start is larger than its end wraps through the sync reference point. This lets the gain gate straddle the sync edge.

The block has two modes. While the line-locking loop is still acquiring, both gates share one overlapped window, which is the gain-gate window. Acquisition is the state after reset, after a change of video standard and after a reload of the subcarrier ratio. Once the lock flag is seen high at a line start, each gate moves to its own programmed window. If lock is lost, the block returns to acquisition at the next line start. A standard-change or ratio-load event forces acquisition on the very next clock.

Top module: `line_gate_gen`

## Requirements
- R1: The position counter becomes 0 on the clock edge that samples `hs_fall` high, and otherwise increases by one on each clock.
- R2: The position counter stops at its all-ones value (1023 for 10 bits) and holds there until the next `hs_fall`. It never rolls over to 0.
- R3: When a window's start is less than or equal to its end, the gate is high exactly while start <= count < end. If start equals end, the gate is never high.
- R4: When a window's start is greater than its end, the gate is high while count >= start or count < end.
- R5: After reset the position counter is 0 and the block is in acquisition mode.
- R6: In acquisition mode, `agc_gate` and `clamp_gate` both follow the window given by `agc_start`/`agc_end`.
- R7: A clock edge with `hs_fall` high, `locked` high and `reacq` low puts the block in tracking mode. In tracking mode, `agc_gate` follows `agc_start`/`agc_end` and `clamp_gate` follows `clamp_start`/`clamp_end`.
- R8: A clock edge with `hs_fall` high and `locked` low puts the block in acquisition mode. A change of `locked` in the middle of a line does not change the mode before the next `hs_fall`.
- R9: `reacq` high puts the block in acquisition mode on the next clock edge, whatever the values of `locked` and `hs_fall`. The block stays in acquisition mode until a line start with `locked` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_fall | input | 1 | One-cycle strobe at the horizontal sync falling edge |
| locked | input | 1 | Line-lock flag from the phase-locked loop |
| reacq | input | 1 | One-cycle strobe for a standard change or ratio reload |
| agc_start | input | 10 | Gain gate start count |
| agc_end | input | 10 | Gain gate end count |
| clamp_start | input | 10 | Clamp gate start count |
| clamp_end | input | 10 | Clamp gate end count |
| agc_gate | output | 1 | Gain sampling gate |
| clamp_gate | output | 1 | Black-level clamp gate |

## Verification
The bench builds the block with its default 10-bit count width. With that width, the programmed example values (a wrapping 0x2F8..0x008 gain window and a 0x020..0x050 clamp window) can be probed at their exact edges. The line can also be run past 1023 counts without a strobe, which exposes saturation against rollover through a window placed at the final count. Mode changes are checked in the middle of a line and at line starts, so lock loss, lock gain and the reload event each show up as a visible swap of the clamp window.

// File: rtl/lg_pkg.sv
package lg_pkg;
    typedef enum logic {
        MODE_ACQ   = 1'b0,
        MODE_TRACK = 1'b1
    } lg_mode_e;
endpackage

// File: rtl/lg_line_counter.sv
module lg_line_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_fall,
    output logic [CNT_W-1:0] pos
);
    localparam logic [CNT_W-1:0] POS_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] pos;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (hs_fall) begin
            s_d.pos = '0;
        end else if (s_q.pos != POS_MAX) begin
            s_d.pos = s_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pos = s_q.pos;

    // R1: a line start restarts the count
    a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
        hs_fall |=> (pos == '0));
    // R1: the count advances by one inside a line
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_fall && pos != POS_MAX) |=> (pos == $past(pos) + 1'b1));
    // R2: the count saturates at the top
    a_r2_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_fall && pos == POS_MAX) |=> (pos == POS_MAX));
endmodule

// File: rtl/lg_mode_ctrl.sv
module lg_mode_ctrl
    import lg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     hs_fall,
    input  logic     locked,
    input  logic     reacq,
    output lg_mode_e mode
);
    typedef struct packed {
        lg_mode_e mode;
    } mode_state_t;

    mode_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (reacq) begin
            s_d.mode = MODE_ACQ;
        end else if (hs_fall) begin
            s_d.mode = locked ? MODE_TRACK : MODE_ACQ;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{mode: MODE_ACQ};
        else        s_q <= s_d;
    end

    assign mode = s_q.mode;

    // R9: a reload event forces acquisition next cycle
    a_r9_reacq: assert property (@(posedge clk) disable iff (!rst_n)
        reacq |=> (mode == MODE_ACQ));
    // R7: lock seen at a line start enters tracking
    a_r7_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_fall && locked && !reacq) |=> (mode == MODE_TRACK));
    // R8: lock absent at a line start returns to acquisition
    a_r8_leave: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_fall && !locked) |=> (mode == MODE_ACQ));
    // R8: no mode change inside a line
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_fall && !reacq) |=> $stable(mode));
endmodule

// File: rtl/lg_window.sv
module lg_window #(
    parameter int CNT_W = 10
) (
    input  logic [CNT_W-1:0] pos,
    input  logic [CNT_W-1:0] win_start,
    input  logic [CNT_W-1:0] win_end,
    output logic             active
);
    logic wraps;
    logic past_start;
    logic before_end;

    always_comb begin
        wraps      = (win_start > win_end);
        past_start = (pos >= win_start);
        before_end = (pos < win_end);
        if (wraps) active = past_start | before_end;
        else       active = past_start & before_end;
    end

    // R3: an empty window never opens
    always_comb begin
        if (win_start == win_end) begin
            a_r3_empty: assert (!active);
        end
    end
endmodule

// File: rtl/line_gate_gen.sv
module line_gate_gen
    import lg_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_fall,
    input  logic             locked,
    input  logic             reacq,
    input  logic [CNT_W-1:0] agc_start,
    input  logic [CNT_W-1:0] agc_end,
    input  logic [CNT_W-1:0] clamp_start,
    input  logic [CNT_W-1:0] clamp_end,
    output logic             agc_gate,
    output logic             clamp_gate
);
    localparam int N_GATE = 2;

    logic [CNT_W-1:0] pos;
    lg_mode_e         mode;
    logic [CNT_W-1:0] sel_start [N_GATE];
    logic [CNT_W-1:0] sel_end   [N_GATE];
    logic [N_GATE-1:0] gate;

    lg_line_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .hs_fall (hs_fall),
        .pos     (pos)
    );

    lg_mode_ctrl u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .hs_fall (hs_fall),
        .locked  (locked),
        .reacq   (reacq),
        .mode    (mode)
    );

    always_comb begin
        sel_start[0] = agc_start;
        sel_end[0]   = agc_end;
        if (mode == MODE_TRACK) begin
            sel_start[1] = clamp_start;
            sel_end[1]   = clamp_end;
        end else begin
            sel_start[1] = agc_start;
            sel_end[1]   = agc_end;
        end
    end

    for (genvar g = 0; g < N_GATE; g++) begin : g_win
        lg_window #(.CNT_W(CNT_W)) u_win (
            .pos       (pos),
            .win_start (sel_start[g]),
            .win_end   (sel_end[g]),
            .active    (gate[g])
        );
    end

    assign agc_gate   = gate[0];
    assign clamp_gate = gate[1];

    // R6: during acquisition the two gates coincide
    a_r6_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ACQ) |-> (agc_gate == clamp_gate));
    // R9: right after a reload event the gates coincide
    a_r9_overlap_next: assert property (@(posedge clk) disable iff (!rst_n)
        reacq |=> (agc_gate == clamp_gate));
endmodule

// File: tb/tb_line_gate_gen.sv
module tb_line_gate_gen;
    localparam int CNT_W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs_fall = 1'b0, locked = 1'b0, reacq = 1'b0;
    logic [CNT_W-1:0] agc_start = '0, agc_end = '0, clamp_start = '0, clamp_end = '0;
    logic agc_gate, clamp_gate;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    line_gate_gen #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .hs_fall(hs_fall), .locked(locked), .reacq(reacq),
        .agc_start(agc_start), .agc_end(agc_end),
        .clamp_start(clamp_start), .clamp_end(clamp_end),
        .agc_gate(agc_gate), .clamp_gate(clamp_gate)
    );

    typedef struct packed {
        logic       lk;
        logic [9:0] as_v;
        logic [9:0] ae_v;
        logic [9:0] cs_v;
        logic [9:0] ce_v;
        logic [9:0] probe;
        logic       ea;
        logic       ec;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 10'h2F8, 10'h008, 10'h020, 10'h050, 10'h000, 1'b1, 1'b0},
        '{1'b1, 10'h2F8, 10'h008, 10'h020, 10'h050, 10'h007, 1'b1, 1'b0},
        '{1'b1, 10'h2F8, 10'h008, 10'h020, 10'h050, 10'h008, 1'b0, 1'b0},
        '{1'b1, 10'h2F8, 10'h008, 10'h020, 10'h050, 10'h020, 1'b0, 1'b1},
        '{1'b1, 10'h2F8, 10'h008, 10'h020, 10'h050, 10'h04F, 1'b0, 1'b1},
        '{1'b1, 10'h2F8, 10'h008, 10'h020, 10'h050, 10'h050, 1'b0, 1'b0},
        '{1'b1, 10'h2F8, 10'h008, 10'h020, 10'h050, 10'h2F7, 1'b0, 1'b0},
        '{1'b1, 10'h2F8, 10'h008, 10'h020, 10'h050, 10'h2F8, 1'b1, 1'b0},
        '{1'b0, 10'h2F8, 10'h008, 10'h020, 10'h050, 10'h020, 1'b0, 1'b0},
        '{1'b0, 10'h2F8, 10'h008, 10'h020, 10'h050, 10'h005, 1'b1, 1'b1},
        '{1'b1, 10'h010, 10'h020, 10'h030, 10'h030, 10'h010, 1'b1, 1'b0},
        '{1'b1, 10'h010, 10'h020, 10'h030, 10'h030, 10'h030, 1'b0, 1'b0},
        '{1'b1, 10'h010, 10'h020, 10'h030, 10'h030, 10'h01F, 1'b1, 1'b0},
        '{1'b1, 10'h010, 10'h020, 10'h030, 10'h030, 10'h020, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic ea, input logic ec);
        n_run++;
        if (agc_gate !== ea || clamp_gate !== ec) begin
            n_fail++;
            $display("FAIL %s: agc=%b clamp=%b expected agc=%b clamp=%b",
                     req, agc_gate, clamp_gate, ea, ec);
        end
    endtask

    task automatic line_start(input logic lk);
        @(negedge clk); locked = lk; hs_fall = 1'b1;
        @(negedge clk); hs_fall = 1'b0;
    endtask

    task automatic advance(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_win(input logic [9:0] a0, a1, c0, c1);
        agc_start = a0; agc_end = a1; clamp_start = c0; clamp_end = c1;
    endtask

    initial begin
        set_win(10'h2F8, 10'h008, 10'h020, 10'h050);
        advance(3);
        // R5: count at 0 and acquisition after reset; wrap window covers 0
        check("R5 reset", 1'b1, 1'b1);
        @(negedge clk); rst_n = 1'b1;
        advance(0);
        check("R5 first cycle", 1'b1, 1'b1);

        // table walk: R3 R4 R6 R7
        for (int i = 0; i < NV; i++) begin
            set_win(VECS[i].as_v, VECS[i].ae_v, VECS[i].cs_v, VECS[i].ce_v);
            line_start(VECS[i].lk);
            advance(int'(VECS[i].probe));
            check($sformatf("R3/R4/R6/R7 vec %0d", i), VECS[i].ea, VECS[i].ec);
        end

        // R8: lock drops mid-line, mode holds until next line start
        set_win(10'h2F8, 10'h008, 10'h020, 10'h050);
        line_start(1'b1);
        advance(32);
        locked = 1'b0;
        advance(1);
        check("R8 hold mid-line", 1'b0, 1'b1);
        line_start(1'b0);
        advance(33);
        check("R8 acquisition after line start", 1'b0, 1'b0);

        // R9: reload event forces acquisition at once, even with lock high
        line_start(1'b1);
        advance(32);
        check("R9 tracking before event", 1'b0, 1'b1);
        reacq = 1'b1;
        advance(1);
        reacq = 1'b0;
        check("R9 acquisition next cycle", 1'b0, 1'b0);
        advance(4);
        check("R9 stays acquisition mid-line", 1'b0, 1'b0);
        line_start(1'b1);
        advance(33);
        check("R9 tracking after locked line start", 1'b0, 1'b1);

        // R1: a strobe mid-line restarts the count
        line_start(1'b1);
        advance(40);
        line_start(1'b1);
        advance(3);
        check("R1 restart", 1'b1, 1'b0);

        // R2: saturation at 1023, window holding only the last count
        set_win(10'h3FF, 10'h000, 10'h030, 10'h030);
        line_start(1'b1);
        advance(1022);
        check("R2 before top", 1'b0, 1'b0);
        advance(1);
        check("R2 at top", 1'b1, 1'b0);
        advance(50);
        check("R2 saturated, no rollover", 1'b1, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule